// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst to a synchronous SRAM. A load strobe captures a starting address from the external bus. The upper bits of that address stay fixed for the whole burst. The two low bits are stepped through one of two orderings, chosen by a static tie-off input.

When the order input is high, the low bits follow an interleaved order: the start bits XOR a beat index. When the order input is low, they follow a linear order: the start bits plus the beat index, wrapping modulo four. An advance input moves to the next beat. With advance low, the address holds, so the burst is suspended.

A beat counter and a last-beat flag let the caller see when the four beats have been used. Further advances wrap back to the first address of the same burst. No new external address is taken unless a load occurs.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets addr_o to zero and beat_o to zero in the next cycle.
- R2: load_i high at a clock edge makes addr_o equal the sampled addr_i and beat_o equal zero from the next cycle on. This happens whatever adv_i is at that edge: load has priority over advance.
- R3: When the order captured at load is 1 (interleaved), addr_o[1:0] equals the start low bits XOR beat_o. For example, start 10 gives 10, 11, 00, 01.
- R4: When the order captured at load is 0 (linear), addr_o[1:0] equals the start low bits plus beat_o, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: adv_i high with load_i low at a clock edge increments beat_o by one, modulo 4.
- R6: adv_i and load_i both low at a clock edge leaves addr_o and beat_o unchanged (the burst is suspended).
- R7: The upper bits addr_o[ADDR_W-1:2] equal those loaded, for every beat of the burst.
- R8: After the fourth beat, an advance returns beat_o to zero and addr_o to the starting address of the burst.
- R9: order_i is sampled only at a load. Changing it during a burst has no effect on addr_o.
- R10: last_o is high exactly when beat_o equals 3, the fourth beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture a new start address and restart the burst |
| adv_i | input | 1 | Step to the next beat |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | SEQ_W | Beat index within the burst |
| last_o | output | 1 | High on the final beat |

## Verification
The bench builds the block with ADDR_W = 6 and SEQ_W = 2. With those values every starting value of the two low bits can be swept in both orders, against two different upper-bit patterns. Each sweep runs six advances, which brings the wrap past the fourth beat into reach. The small address width also makes it cheap to toggle the order input during a burst, to interleave suspended cycles, and to raise load and advance together.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
   parameter int SEQ_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart_i,
   input  logic             step_i,
   output logic [SEQ_W-1:0] beat_o,
   output logic             last_o
);

   localparam logic [SEQ_W-1:0] LAST_BEAT = {SEQ_W{1'b1}};

   generate
      if (SEQ_W < 1) begin : g_bad_width
         $error("bsq_beat_ctr: SEQ_W must be at least 1");
      end
   endgenerate

   logic [SEQ_W-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_q <= '0;
      end else if (restart_i) begin
         beat_q <= '0;
      end else if (step_i) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   assign beat_o = beat_q;
   assign last_o = (beat_q == LAST_BEAT);

   assert_restart_zero_R2: assert property (@(posedge clk) disable iff (rst)
      restart_i |=> (beat_o == '0));

   assert_step_inc_R5: assert property (@(posedge clk) disable iff (rst)
      (!restart_i && step_i) |=> (beat_o == SEQ_W'($past(beat_o) + 1'b1)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!restart_i && !step_i) |=> $stable(beat_o));

   assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (!restart_i && step_i && last_o) |=> (beat_o == '0));

endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              order_i,
   output logic [ADDR_W-1:0] base_o,
   output order_e            order_o
);

   logic [ADDR_W-1:0] base_q;
   order_e            order_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q  <= '0;
         order_q <= ORD_INTERLEAVE;
      end else if (load_i) begin
         base_q  <= addr_i;
         order_q <= order_e'(order_i);
      end
   end

   assign base_o  = base_q;
   assign order_o = order_q;

   assert_base_held_R7: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(base_o));

   assert_order_held_R9: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(order_o));

endmodule

// File: rtl/bsq_order.sv
module bsq_order
   import bsq_pkg::*;
#(
   parameter int SEQ_W = 2
) (
   input  logic [SEQ_W-1:0] start_i,
   input  logic [SEQ_W-1:0] beat_i,
   input  order_e           order_i,
   output logic [SEQ_W-1:0] low_o
);

   logic [SEQ_W-1:0] ilv;
   logic [SEQ_W-1:0] lin;
   logic [SEQ_W-1:0] carry;

   assign carry[0] = 1'b0;

   genvar i;
   generate
      for (i = 0; i < SEQ_W; i++) begin : g_bit
         assign ilv[i] = start_i[i] ^ beat_i[i];
         assign lin[i] = start_i[i] ^ beat_i[i] ^ carry[i];
         if (i < SEQ_W - 1) begin : g_carry
            assign carry[i+1] = (start_i[i] & beat_i[i]) |
                                (carry[i] & (start_i[i] ^ beat_i[i]));
         end
      end
   endgenerate

   assign low_o = (order_i == ORD_INTERLEAVE) ? ilv : lin;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SEQ_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic              order_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SEQ_W-1:0]  beat_o,
   output logic              last_o
);

   localparam int HI_W = ADDR_W - SEQ_W;

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("burst_addr_seq: ADDR_W must exceed SEQ_W");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   order_e            order_q;
   logic [SEQ_W-1:0]  beat;
   logic [SEQ_W-1:0]  low;

   bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load_i),
      .addr_i  (addr_i),
      .order_i (order_i),
      .base_o  (base),
      .order_o (order_q)
   );

   bsq_beat_ctr #(.SEQ_W(SEQ_W)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .restart_i (load_i),
      .step_i    (adv_i),
      .beat_o    (beat),
      .last_o    (last_o)
   );

   bsq_order #(.SEQ_W(SEQ_W)) u_ord (
      .start_i (base[SEQ_W-1:0]),
      .beat_i  (beat),
      .order_i (order_q),
      .low_o   (low)
   );

   assign addr_o = {base[ADDR_W-1:SEQ_W], low};
   assign beat_o = beat;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (addr_o == '0 && beat_o == '0));

   assert_load_addr_R2: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (addr_o == $past(addr_i)));

   assert_suspend_R6: assert property (@(posedge clk) disable iff (rst)
      (!load_i && !adv_i) |=> $stable(addr_o));

   assert_upper_held_R7: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(addr_o[ADDR_W-1:SEQ_W]));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

   localparam int AW = 6;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          load_i;
   logic          adv_i;
   logic          order_i;
   logic [AW-1:0] addr_i;
   logic [AW-1:0] addr_o;
   logic [SW-1:0] beat_o;
   logic          last_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   logic [AW-1:0] m_base;
   logic          m_ord;
   int            m_beat;

   always #5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .SEQ_W(SW)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load_i),
      .adv_i   (adv_i),
      .order_i (order_i),
      .addr_i  (addr_i),
      .addr_o  (addr_o),
      .beat_o  (beat_o),
      .last_o  (last_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_addr();
      int lo;
      lo = m_ord ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
      return (int'(m_base[AW-1:2]) << 2) | lo;
   endfunction

   // drive at a negedge, let one posedge pass, return at the next negedge
   task automatic cyc(input logic ld, input logic ad, input logic od, input logic [AW-1:0] a);
      load_i  = ld;
      adv_i   = ad;
      order_i = od;
      addr_i  = a;
      @(posedge clk);
      @(negedge clk);
      if (ld) begin
         m_base = a; m_ord = od; m_beat = 0;
      end else if (ad) begin
         m_beat = (m_beat + 1) % 4;
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " addr"}, int'(addr_o), exp_addr());
      check({tag, " beat R5"}, int'(beat_o), m_beat);
      check({tag, " last R10"}, int'(last_o), int'(m_beat == 3));
      check({tag, " upper R7"}, int'(addr_o[AW-1:2]), int'(m_base[AW-1:2]));
   endtask

   initial begin
      while (cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; load_i = 1'b0; adv_i = 1'b0; order_i = 1'b1; addr_i = '0;
      @(negedge clk);
      cyc(1'b0, 1'b1, 1'b1, 6'h2b);
      // R1 reset state
      check("R1 addr", int'(addr_o), 0);
      check("R1 beat", int'(beat_o), 0);
      rst = 1'b0;
      m_base = '0; m_ord = 1'b1; m_beat = 0;

      // R3/R4/R8: sweep both orders, all starts, two upper patterns, six advances
      for (int od = 0; od < 2; od++) begin
         for (int up = 0; up < 2; up++) begin
            for (int st = 0; st < 4; st++) begin
               logic [AW-1:0] a;
               a = AW'(((up ? 'hb : 'h4) << 2) | st);
               cyc(1'b1, 1'b0, od[0], a);
               check("R2 load addr", int'(addr_o), int'(a));
               check("R2 load beat", int'(beat_o), 0);
               for (int k = 0; k < 6; k++) begin
                  check_all(od ? "R3 interleave" : "R4 linear");
                  if (k == 4) check("R8 wrap to start", int'(addr_o), int'(a));
                  cyc(1'b0, 1'b1, od[0], ~a);
               end
            end
         end
      end

      // R3 explicit table: start 10 interleaved gives 10 11 00 01
      cyc(1'b1, 1'b0, 1'b1, 6'h2a);
      check("R3 beat0", int'(addr_o[1:0]), 2);
      cyc(1'b0, 1'b1, 1'b1, '0);
      check("R3 beat1", int'(addr_o[1:0]), 3);
      cyc(1'b0, 1'b1, 1'b1, '0);
      check("R3 beat2", int'(addr_o[1:0]), 0);
      cyc(1'b0, 1'b1, 1'b1, '0);
      check("R3 beat3", int'(addr_o[1:0]), 1);

      // R4 explicit: start 11 linear gives 11 00 01 10
      cyc(1'b1, 1'b0, 1'b0, 6'h13);
      cyc(1'b0, 1'b1, 1'b0, '0);
      check("R4 beat1", int'(addr_o[1:0]), 0);
      cyc(1'b0, 1'b1, 1'b0, '0);
      check("R4 beat2", int'(addr_o[1:0]), 1);

      // R6 suspend, with R9 order toggling mid-burst
      for (int k = 0; k < 4; k++) begin
         cyc(1'b0, 1'b0, k[0], 6'h3f);
         check_all("R6 suspend");
      end
      for (int k = 0; k < 5; k++) begin
         cyc(1'b0, 1'b1, k[0], 6'h00);
         check_all("R9 order ignored");
      end

      // R9: interleaved burst, order low during advances; start 01 stays 01 00 11 10
      cyc(1'b1, 1'b0, 1'b1, 6'h05);
      cyc(1'b0, 1'b1, 1'b0, '0);
      check("R9 beat1", int'(addr_o[1:0]), 0);
      cyc(1'b0, 1'b1, 1'b0, '0);
      check("R9 beat2", int'(addr_o[1:0]), 3);

      // R2 priority: load together with advance
      cyc(1'b0, 1'b1, 1'b0, '0);
      cyc(1'b1, 1'b1, 1'b0, 6'h1e);
      check("R2 load over adv addr", int'(addr_o), 'h1e);
      check("R2 load over adv beat", int'(beat_o), 0);
      check_all("R2 after load");

      // R1 reset mid-burst
      cyc(1'b0, 1'b1, 1'b0, '0);
      rst = 1'b1;
      cyc(1'b0, 1'b1, 1'b0, '0);
      rst = 1'b0;
      check("R1 mid-burst addr", int'(addr_o), 0);
      check("R1 mid-burst beat", int'(beat_o), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule